// File: doc/BRIEF.md
# Legacy Graphics I/O Port Router

This block decides where each downstream I/O cycle is sent. Three targets are possible: the PCI Express graphics port, the legacy bus that sits below the bridge, or none at all when no cycle is presented. The decision depends on the 16-bit I/O address, two forwarding controls, a flag that says a monochrome adapter is present on the legacy bus, and one base/limit window for devices behind the graphics port.

The block keeps the fixed colour display ports apart from the six monochrome display ports. When the monochrome flag is set, those six ports are taken away from the graphics port even if forwarding or the window would otherwise claim them. A master I/O enable can cut off every I/O route to the graphics port. Any address that nothing claims goes to the legacy bus, which is the subtractive default.

The decision is registered, so the result appears one clock after the cycle strobe. It comes with its own valid flag.

Top module: `io_route_decoder`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rt_vld` is 0 and `rt_tgt` is 2'b00.
- R2: `rt_vld` equals `cyc_vld` of the previous clock. When `rt_vld` is 0, `rt_tgt` is 2'b00. When `rt_vld` is 1, exactly one bit of `rt_tgt` is set: bit 0 means the graphics port and bit 1 means the legacy bus.
- R3: When `io_en` is 0, every cycle goes to the legacy bus (2'b10), whatever the address, the window and the other controls.
- R4: When `io_en` and `mono_present` are both 1, a monochrome port goes to the legacy bus (2'b10). This holds even if the port lies in the colour range or inside the window.
- R5: The monochrome ports are exactly 3B4h, 3B5h, 3B8h, 3B9h, 3BAh and 3BFh, with all upper address bits zero. Neighbours such as 3B6h, 3BBh and 3BEh are not monochrome ports.
- R6: When `io_en` and `vga_en` are both 1, an address in 3B0h–3BBh or 3C0h–3DFh goes to the graphics port (2'b01), unless R4 takes it.
- R7: When `vga_en` is 0, the colour display ranges get no special treatment. They are routed only by the window or by the default.
- R8: The window compares address bits [15:12] against `win_base` and `win_limit`, with both ends included (4 KB granularity). When `io_en` is 1 and the window is hit, the cycle goes to the graphics port, unless R4 takes it.
- R9: When `win_limit` is less than `win_base`, the window matches no address.
- R10: A cycle that none of R4, R6 or R8 sends to the graphics port goes to the legacy bus (2'b10).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_vld | input | 1 | An I/O cycle is presented this clock |
| cyc_addr | input | 16 | I/O address of the cycle |
| vga_en | input | 1 | Forward the legacy display ranges to the graphics port |
| io_en | input | 1 | Master enable for I/O routing to the graphics port |
| mono_present | input | 1 | A monochrome adapter sits on the legacy bus |
| win_base | input | 4 | Window base, address bits [15:12] |
| win_limit | input | 4 | Window limit, address bits [15:12] |
| rt_vld | output | 1 | Routing result is valid (one clock after `cyc_vld`) |
| rt_tgt | output | 2 | One-hot target: bit 0 graphics port, bit 1 legacy bus |

## Verification
The monochrome rule and the colour-range or window claim can apply to the same address in the same cycle. This happens for 3B4h–3BAh, which lie inside the colour range, and for any monochrome port when the window covers the 0xxxh block. The bench sets up that overlap by sweeping every address from 380h to 3FFh. It does this under all eight settings of the three control bits and under window settings that cover, miss and disable the low block. Each result is judged against a priority model in the bench: the monochrome claim must win, and the master enable must override both claims.

// File: rtl/io_route_pkg.sv
package io_route_pkg;

    // Legacy ports live in the low 1 KB of I/O space
    localparam int LEG_W    = 10;
    localparam int MONO_CNT = 6;
    localparam int CLR_CNT  = 2;

    localparam logic [LEG_W-1:0] MONO_PORTS [MONO_CNT] =
        '{10'h3B4, 10'h3B5, 10'h3B8, 10'h3B9, 10'h3BA, 10'h3BF};

    typedef struct packed {
        logic [LEG_W-1:0] lo;
        logic [LEG_W-1:0] hi;
    } port_range_s;

    localparam port_range_s CLR_RANGES [CLR_CNT] =
        '{'{lo: 10'h3B0, hi: 10'h3BB}, '{lo: 10'h3C0, hi: 10'h3DF}};

    typedef enum logic [1:0] {
        TGT_IDLE   = 2'b00,
        TGT_GFX    = 2'b01,
        TGT_LEGACY = 2'b10
    } route_tgt_e;

    typedef struct packed {
        logic mono;
        logic colour;
        logic window;
    } addr_hits_s;

    typedef struct packed {
        logic vga_fwd;
        logic io_fwd;
        logic mono_dev;
    } route_ctl_s;

endpackage

// File: rtl/io_legacy_match.sv
module io_legacy_match
    import io_route_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              mono_hit,
    output logic              colour_hit
);
    localparam int HI_W = ADDR_W - LEG_W;

    logic                 low_page;
    logic [LEG_W-1:0]     low_addr;
    logic [MONO_CNT-1:0]  mono_vec;
    logic [CLR_CNT-1:0]   clr_vec;

    assign low_page = (addr[ADDR_W-1:LEG_W] == '0);
    assign low_addr = addr[LEG_W-1:0];

    for (genvar i = 0; i < MONO_CNT; i++) begin : g_mono
        assign mono_vec[i] = (low_addr == MONO_PORTS[i]);
    end

    for (genvar j = 0; j < CLR_CNT; j++) begin : g_clr
        assign clr_vec[j] = (low_addr >= CLR_RANGES[j].lo) &&
                            (low_addr <= CLR_RANGES[j].hi);
    end

    assign mono_hit   = low_page && (|mono_vec);
    assign colour_hit = low_page && (|clr_vec);

    if (HI_W < 1) begin : g_bad_width
        initial $error("io_legacy_match: ADDR_W must exceed %0d", LEG_W);
    end
endmodule

// File: rtl/io_window_match.sv
module io_window_match #(
    parameter int ADDR_W = 16,
    parameter int GRAN_W = 12,
    localparam int WIN_W = ADDR_W - GRAN_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIN_W-1:0]  base,
    input  logic [WIN_W-1:0]  limit,
    output logic              win_hit
);
    logic [WIN_W-1:0] page;
    logic             win_open;

    assign page     = addr[ADDR_W-1:GRAN_W];
    assign win_open = (limit >= base);
    assign win_hit  = win_open && (page >= base) && (page <= limit);
endmodule

// File: rtl/io_route_select.sv
module io_route_select
    import io_route_pkg::*;
(
    input  addr_hits_s hits,
    input  route_ctl_s ctl,
    output route_tgt_e tgt
);
    always_comb begin
        if (!ctl.io_fwd)
            tgt = TGT_LEGACY;
        else if (ctl.mono_dev && hits.mono)
            tgt = TGT_LEGACY;
        else if (ctl.vga_fwd && hits.colour)
            tgt = TGT_GFX;
        else if (hits.window)
            tgt = TGT_GFX;
        else
            tgt = TGT_LEGACY;
    end
endmodule

// File: rtl/io_route_decoder.sv
module io_route_decoder
    import io_route_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int GRAN_W = 12,
    localparam int WIN_W = ADDR_W - GRAN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_vld,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              vga_en,
    input  logic              io_en,
    input  logic              mono_present,
    input  logic [WIN_W-1:0]  win_base,
    input  logic [WIN_W-1:0]  win_limit,
    output logic              rt_vld,
    output logic [1:0]        rt_tgt
);
    addr_hits_s hits;
    route_ctl_s ctl;
    route_tgt_e tgt_nxt;
    route_tgt_e tgt_q;
    logic       vld_q;

    io_legacy_match #(.ADDR_W(ADDR_W)) u_legacy (
        .addr       (cyc_addr),
        .mono_hit   (hits.mono),
        .colour_hit (hits.colour)
    );

    io_window_match #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W)) u_window (
        .addr    (cyc_addr),
        .base    (win_base),
        .limit   (win_limit),
        .win_hit (hits.window)
    );

    assign ctl = '{vga_fwd: vga_en, io_fwd: io_en, mono_dev: mono_present};

    io_route_select u_select (
        .hits (hits),
        .ctl  (ctl),
        .tgt  (tgt_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            tgt_q <= TGT_IDLE;
        end else begin
            vld_q <= cyc_vld;
            tgt_q <= cyc_vld ? tgt_nxt : TGT_IDLE;
        end
    end

    assign rt_vld = vld_q;
    assign rt_tgt = tgt_q;
endmodule

// File: rtl/io_route_checker.sv
module io_route_checker
    import io_route_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int GRAN_W = 12,
    localparam int WIN_W = ADDR_W - GRAN_W
) (
    input logic              clk,
    input logic              rst,
    input logic              cyc_vld,
    input logic [ADDR_W-1:0] cyc_addr,
    input logic              vga_en,
    input logic              io_en,
    input logic              mono_present,
    input logic [WIN_W-1:0]  win_base,
    input logic [WIN_W-1:0]  win_limit,
    input logic              rt_vld,
    input logic [1:0]        rt_tgt
);
    logic is_mono;
    always_comb begin
        is_mono = 1'b0;
        for (int k = 0; k < MONO_CNT; k++)
            if (cyc_addr == ADDR_W'(MONO_PORTS[k])) is_mono = 1'b1;
    end

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_vld |=> rt_vld);

    // R2
    vld_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_vld |=> (!rt_vld && rt_tgt == 2'b00));

    // R2
    tgt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        rt_vld |-> ($countones(rt_tgt) == 1));

    // R3
    io_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_vld && !io_en) |=> (rt_tgt == 2'b10));

    // R4
    mono_claim_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_vld && mono_present && is_mono) |=> (rt_tgt == 2'b10));

    // R9
    win_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_vld && !vga_en && (win_limit < win_base)) |=> (rt_tgt == 2'b10));
endmodule

bind io_route_decoder io_route_checker #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W)) u_route_chk (
    .clk          (clk),
    .rst          (rst),
    .cyc_vld      (cyc_vld),
    .cyc_addr     (cyc_addr),
    .vga_en       (vga_en),
    .io_en        (io_en),
    .mono_present (mono_present),
    .win_base     (win_base),
    .win_limit    (win_limit),
    .rt_vld       (rt_vld),
    .rt_tgt       (rt_tgt)
);

// File: tb/tb_io_route_decoder.sv
module tb_io_route_decoder;
    logic        clk = 1'b0;
    logic        rst;
    logic        cyc_vld;
    logic [15:0] cyc_addr;
    logic        vga_en, io_en, mono_present;
    logic [3:0]  win_base, win_limit;
    logic        rt_vld;
    logic [1:0]  rt_tgt;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    io_route_decoder dut (
        .clk(clk), .rst(rst), .cyc_vld(cyc_vld), .cyc_addr(cyc_addr),
        .vga_en(vga_en), .io_en(io_en), .mono_present(mono_present),
        .win_base(win_base), .win_limit(win_limit),
        .rt_vld(rt_vld), .rt_tgt(rt_tgt)
    );

    function automatic bit mono_port(input logic [15:0] a);
        return a == 16'h3B4 || a == 16'h3B5 || a == 16'h3B8 ||
               a == 16'h3B9 || a == 16'h3BA || a == 16'h3BF;
    endfunction

    function automatic bit colour_port(input logic [15:0] a);
        return (a >= 16'h3B0 && a <= 16'h3BB) || (a >= 16'h3C0 && a <= 16'h3DF);
    endfunction

    // expected target and the requirement that decided it
    task automatic model(input logic [15:0] a, output logic [1:0] exp, output string tag);
        bit win = (win_limit >= win_base) && (a[15:12] >= win_base) && (a[15:12] <= win_limit);
        if (!io_en) begin
            exp = 2'b10; tag = "R3";
        end else if (mono_present && mono_port(a)) begin
            exp = 2'b10; tag = "R4/R5";
        end else if (vga_en && colour_port(a)) begin
            exp = 2'b01; tag = "R6";
        end else if (win) begin
            exp = 2'b01; tag = (colour_port(a) ? "R7/R8" : "R8");
        end else begin
            exp = 2'b10;
            tag = (win_limit < win_base) ? "R9/R10" : (colour_port(a) ? "R7/R10" : "R10");
        end
    endtask

    task automatic check(input string tag, input logic v, input logic [1:0] t,
                         input logic ev, input logic [1:0] et);
        n_run++;
        if (rt_vld !== ev || rt_tgt !== et) begin
            n_fail++;
            $display("FAIL %s: got vld=%0b tgt=%b, expected vld=%0b tgt=%b",
                     tag, v, t, ev, et);
        end
    endtask

    // drive one cycle at the falling edge, sample the registered result one clock later
    task automatic probe(input logic [15:0] a);
        logic [1:0] exp;
        string tag;
        model(a, exp, tag);
        cyc_vld  = 1'b1;
        cyc_addr = a;
        @(negedge clk);
        cyc_vld = 1'b0;
        check($sformatf("%s addr=%h", tag, a), rt_vld, rt_tgt, 1'b1, exp);
    endtask

    task automatic idle_check();
        cyc_vld  = 1'b0;
        cyc_addr = 16'h3C0;
        @(negedge clk);
        check("R2 idle", rt_vld, rt_tgt, 1'b0, 2'b00);
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog: got hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cyc_vld = 1'b1; cyc_addr = 16'h3C0;
        vga_en = 1'b1; io_en = 1'b1; mono_present = 1'b0;
        win_base = 4'h0; win_limit = 4'hF;
        repeat (3) @(negedge clk);
        check("R1 in reset", rt_vld, rt_tgt, 1'b0, 2'b00);
        cyc_vld = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", rt_vld, rt_tgt, 1'b0, 2'b00);

        // window settings: 0 covers 0xxxh, 1 covers 1xxxh-2xxxh, 2 disabled, 3 single page 3xxxh
        for (int w = 0; w < 4; w++) begin
            case (w)
                0: begin win_base = 4'h0; win_limit = 4'h0; end
                1: begin win_base = 4'h1; win_limit = 4'h2; end
                2: begin win_base = 4'h5; win_limit = 4'h4; end
                default: begin win_base = 4'h3; win_limit = 4'h3; end
            endcase
            for (int c = 0; c < 8; c++) begin
                io_en        = c[0];
                vga_en       = c[1];
                mono_present = c[2];
                for (int a = 16'h380; a < 16'h400; a++) probe(16'(a));
                probe(16'h0000); probe(16'h0FFF);
                probe(16'h1000); probe(16'h2FFF);
                probe(16'h3000); probe(16'h3FFF);
                probe(16'h43B4); probe(16'h13C0);
                probe(16'h4000); probe(16'hFFFF);
                idle_check();
            end
        end

        // back-to-back cycles with gaps: R2 timing
        io_en = 1'b1; vga_en = 1'b1; mono_present = 1'b1;
        win_base = 4'h2; win_limit = 4'h1;
        probe(16'h3D4);
        probe(16'h3B4);
        idle_check();
        probe(16'h0080);
        idle_check();
        idle_check();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule